// File: doc/BRIEF.md
# Instrumentation Trace Stimulus Packetizer

This block lets software stream debug values off the chip over one wire without waiting on a slow UART. It has 32 stimulus ports at consecutive word addresses. A store to an enabled port becomes a trace packet. The packet is a header byte that names the port and the payload size, followed by the payload bytes, least significant first. The payload size comes from the width of the store, given by its byte strobes.

Packet bytes go into a byte FIFO. A serializer drains the FIFO onto an NRZ line framed like a UART. The bit period is the prescaler register value plus one reference clocks, so a 150 MHz reference gives exactly 6, 3, 2 and 1 Mbit/s for prescaler values 24, 49, 74 and 149.

Software reads a port to learn whether the FIFO still has room for a largest packet. It writes only when that flag is set. When the line has been quiet for a set time, the block can also insert a synchronization packet so that a receiver can find packet boundaries.

Top module: `trace_stim_pkt`

## Requirements
- R1: The serial line idles high. Each byte is sent as one low start bit, then eight data bits LSB first, then one high stop bit.
- R2: Word addresses 0 to 31 are stimulus ports 0 to 31. A write with strobes 0001 sends header {port[4:0], 0, 01} followed by data[7:0].
- R3: A write with strobes 0011 sends header size code 10, followed by data[7:0] and then data[15:8].
- R4: A write with strobes 1111 sends one 5-byte packet: header size code 11, then data bytes 0, 1, 2, 3.
- R5: A port write with any other strobe pattern produces no packet.
- R6: Reading a port returns bit 0 = 1 while the FIFO has at least 5 free bytes, and 0 otherwise. A port write made while the flag is 0 is dropped.
- R7: Word address 32 is the port enable register, where bit n enables port n. A write to a disabled port produces no packet.
- R8: Word address 33 is the control register: bit 0 global enable, bit 1 sync enable, bit 2 transmit enable, bit 3 serial-output enable, bits 14:8 trace ID. It reads back as written. While bit 0 is clear, no packet is produced.
- R9: Word address 34 holds a 16-bit prescaler. Every bit on the line lasts prescaler + 1 clock cycles.
- R10: While transmit enable is clear, queued bytes stay in the FIFO and the line stays high. Setting transmit enable sends them in order.
- R11: While serial-output enable is clear, the line is held high.
- R12: With global and sync enable set, once the FIFO has been empty and the serializer idle for SYNC_IDLE cycles, the bytes 00 00 00 00 00 80 are sent.
- R13: The FIFO holds FIFO_DEPTH (default 16) bytes, never overflows, and sends bytes in the order they were queued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 6 | Word address |
| bus_strb | input | 4 | Byte lane strobes of a write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| swo_o | output | 1 | Serial trace output line |

## Verification
The assertions assume that the prescaler is changed only while the line is idle. They also assume that no packet is pushed while the FIFO reports too little room; the block's own ready gating guarantees this, and the sync packet is only issued into an empty FIFO.

The bench writes the prescaler only after its scoreboard has drained. It enables sync only while the FIFO is empty, and clears it within a few cycles of the synchronization bytes leaving, so that no second sync packet is produced. The ready-flag test fills the FIFO with back-to-back word writes under a long bit period, so that exactly one byte is popped before the flag is read.

// File: rtl/trace_pkg.sv
package trace_pkg;

    localparam int NUM_PORTS  = 32;
    localparam int ADDR_W     = 6;
    localparam logic [ADDR_W-1:0] ADDR_EN    = 6'd32;
    localparam logic [ADDR_W-1:0] ADDR_CTRL  = 6'd33;
    localparam logic [ADDR_W-1:0] ADDR_PRESC = 6'd34;
    localparam int PKT_MAX    = 5;   // header + four payload bytes
    localparam int PUSH_MAX   = 6;   // sync packet length
    localparam int PUSH_CNT_W = $clog2(PUSH_MAX + 1);

    typedef logic [7:0] byte_t;

    typedef enum logic [1:0] {
        SZ_NONE = 2'b00,
        SZ_B    = 2'b01,
        SZ_H    = 2'b10,
        SZ_W    = 2'b11
    } size_e;

    typedef struct packed {
        logic [6:0] trace_id;
        logic       ser_en;
        logic       tx_en;
        logic       sync_en;
        logic       glob_en;
    } ctrl_t;

    function automatic logic [31:0] ctrl_to_word(input ctrl_t c);
        return {17'b0, c.trace_id, 4'b0, c.ser_en, c.tx_en, c.sync_en, c.glob_en};
    endfunction

    function automatic ctrl_t ctrl_from_word(input logic [31:0] w);
        ctrl_t c;
        c.trace_id = w[14:8];
        c.ser_en   = w[3];
        c.tx_en    = w[2];
        c.sync_en  = w[1];
        c.glob_en  = w[0];
        return c;
    endfunction

    function automatic size_e size_from_strb(input logic [3:0] s);
        case (s)
            4'b0001: return SZ_B;
            4'b0011: return SZ_H;
            4'b1111: return SZ_W;
            default: return SZ_NONE;
        endcase
    endfunction

    function automatic logic [PUSH_CNT_W-1:0] payload_len(input size_e sz);
        case (sz)
            SZ_B:    return PUSH_CNT_W'(1);
            SZ_H:    return PUSH_CNT_W'(2);
            SZ_W:    return PUSH_CNT_W'(4);
            default: return PUSH_CNT_W'(0);
        endcase
    endfunction

    function automatic byte_t make_header(input logic [4:0] port, input size_e sz);
        return {port, 1'b0, sz};
    endfunction

    function automatic logic [31:0] merge_strb(input logic [31:0] old_v,
                                               input logic [31:0] new_v,
                                               input logic [3:0]  strb);
        logic [31:0] r;
        for (int i = 0; i < 4; i++)
            r[i*8 +: 8] = strb[i] ? new_v[i*8 +: 8] : old_v[i*8 +: 8];
        return r;
    endfunction

endpackage

// File: rtl/trace_byte_fifo.sv
module trace_byte_fifo
    import trace_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int AW = $clog2(DEPTH),
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [PUSH_CNT_W-1:0]   push_n,
    input  byte_t [PUSH_MAX-1:0]    push_bytes,
    input  logic                    pop,
    output byte_t                   head,
    output logic [CW-1:0]           fill,
    output logic                    empty,
    output logic                    room_ok
);
    // DEPTH must be a power of two so that pointers wrap naturally.
    byte_t          mem [DEPTH];
    logic [AW-1:0]  wp, rp;
    logic [CW-1:0]  cnt;

    always_ff @(posedge clk) begin
        for (int i = 0; i < PUSH_MAX; i++)
            if (i < int'(push_n))
                mem[wp + AW'(i)] <= push_bytes[i];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            wp  <= wp + AW'(push_n);
            rp  <= rp + AW'(pop);
            cnt <= cnt + CW'(push_n) - CW'(pop);
        end
    end

    assign head    = mem[rp];
    assign fill    = cnt;
    assign empty   = (cnt == '0);
    assign room_ok = (cnt <= CW'(DEPTH - PKT_MAX));

endmodule

// File: rtl/trace_nrz_tx.sv
module trace_nrz_tx
    import trace_pkg::*;
#(
    parameter int PRESC_W = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [PRESC_W-1:0] presc,
    input  logic               tx_en,
    input  logic               have_byte,
    input  byte_t              tx_byte,
    output logic               pop,
    output logic               line,
    output logic               busy
);
    localparam int FRAME_BITS = 10;
    localparam int BC_W = $clog2(FRAME_BITS);

    logic [FRAME_BITS-1:0] shreg;
    logic [PRESC_W-1:0]    div;
    logic [BC_W-1:0]       bitn;
    logic                  bit_end, finishing;

    always_comb begin
        bit_end   = busy && (div == presc);
        finishing = bit_end && (bitn == BC_W'(FRAME_BITS - 1));
        pop       = tx_en && have_byte && (!busy || finishing);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy  <= 1'b0;
            shreg <= '1;
            div   <= '0;
            bitn  <= '0;
        end else if (pop) begin
            busy  <= 1'b1;
            shreg <= {1'b1, tx_byte, 1'b0};
            div   <= '0;
            bitn  <= '0;
        end else if (busy) begin
            if (bit_end) begin
                div   <= '0;
                shreg <= {1'b1, shreg[FRAME_BITS-1:1]};
                if (finishing) busy <= 1'b0;
                else           bitn <= bitn + 1'b1;
            end else begin
                div <= div + 1'b1;
            end
        end
    end

    assign line = busy ? shreg[0] : 1'b1;

endmodule

// File: rtl/trace_sync_timer.sv
module trace_sync_timer #(
    parameter int IDLE = 32,
    localparam int W = $clog2(IDLE + 1)
) (
    input  logic clk,
    input  logic rst,
    input  logic arm,
    input  logic idle,
    input  logic hold,
    output logic fire
);
    logic [W-1:0] cnt;
    logic         at_limit;

    assign at_limit = (cnt == W'(IDLE - 1));
    assign fire     = arm && idle && !hold && at_limit;

    always_ff @(posedge clk) begin
        if (rst || !arm || !idle || fire)
            cnt <= '0;
        else if (!at_limit)
            cnt <= cnt + 1'b1;
    end

endmodule

// File: rtl/trace_stim_pkt.sv
module trace_stim_pkt
    import trace_pkg::*;
#(
    parameter int FIFO_DEPTH = 16,
    parameter int SYNC_IDLE  = 32,
    parameter int PRESC_W    = 16,
    localparam int FILL_W    = $clog2(FIFO_DEPTH + 1)
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        bus_wr,
    input  logic [5:0]  bus_addr,
    input  logic [3:0]  bus_strb,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    output logic        swo_o
);
    logic [NUM_PORTS-1:0] port_en;
    ctrl_t                ctrl_q;
    logic [PRESC_W-1:0]   presc_q;

    logic                  is_port;
    logic [4:0]            port_idx;
    size_e                 sz;
    logic                  pkt_ok, sync_fire;
    logic [PUSH_CNT_W-1:0] push_n;
    byte_t [PUSH_MAX-1:0]  push_bytes;

    byte_t             fifo_head;
    logic [FILL_W-1:0] fifo_fill;
    logic              fifo_empty, fifo_room, tx_pop, tx_line, tx_busy;

    assign is_port  = !bus_addr[5];
    assign port_idx = bus_addr[4:0];
    assign sz       = size_from_strb(bus_strb);
    assign pkt_ok   = bus_wr && is_port && ctrl_q.glob_en && port_en[port_idx]
                      && fifo_room && (sz != SZ_NONE);

    // Register bank
    always_ff @(posedge clk) begin
        if (rst) begin
            port_en <= '0;
            ctrl_q  <= '0;
            presc_q <= '0;
        end else if (bus_wr) begin
            case (bus_addr)
                ADDR_EN:    port_en <= merge_strb(port_en, bus_wdata, bus_strb);
                ADDR_CTRL:  ctrl_q  <= ctrl_from_word(
                                merge_strb(ctrl_to_word(ctrl_q), bus_wdata, bus_strb));
                ADDR_PRESC: presc_q <= PRESC_W'(
                                merge_strb(32'(presc_q), bus_wdata, bus_strb));
                default: ;
            endcase
        end
    end

    always_comb begin
        if (is_port) begin
            bus_rdata = {31'b0, fifo_room};
        end else begin
            case (bus_addr)
                ADDR_EN:    bus_rdata = port_en;
                ADDR_CTRL:  bus_rdata = ctrl_to_word(ctrl_q);
                ADDR_PRESC: bus_rdata = 32'(presc_q);
                default:    bus_rdata = '0;
            endcase
        end
    end

    // Packet assembly: a port write wins over a pending sync packet
    always_comb begin
        push_n     = '0;
        push_bytes = '0;
        if (pkt_ok) begin
            push_bytes[0] = make_header(port_idx, sz);
            for (int i = 1; i < PKT_MAX; i++)
                push_bytes[i] = bus_wdata[(i-1)*8 +: 8];
            push_n = payload_len(sz) + 1'b1;
        end else if (sync_fire) begin
            push_bytes[PUSH_MAX-1] = 8'h80;
            push_n = PUSH_CNT_W'(PUSH_MAX);
        end
    end

    trace_sync_timer #(.IDLE(SYNC_IDLE)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .arm  (ctrl_q.glob_en && ctrl_q.sync_en),
        .idle (fifo_empty && !tx_busy),
        .hold (pkt_ok),
        .fire (sync_fire)
    );

    trace_byte_fifo #(.DEPTH(FIFO_DEPTH)) u_fifo (
        .clk        (clk),
        .rst        (rst),
        .push_n     (push_n),
        .push_bytes (push_bytes),
        .pop        (tx_pop),
        .head       (fifo_head),
        .fill       (fifo_fill),
        .empty      (fifo_empty),
        .room_ok    (fifo_room)
    );

    trace_nrz_tx #(.PRESC_W(PRESC_W)) u_tx (
        .clk       (clk),
        .rst       (rst),
        .presc     (presc_q),
        .tx_en     (ctrl_q.tx_en),
        .have_byte (!fifo_empty),
        .tx_byte   (fifo_head),
        .pop       (tx_pop),
        .line      (tx_line),
        .busy      (tx_busy)
    );

    assign swo_o = ctrl_q.ser_en ? tx_line : 1'b1;

endmodule

// File: rtl/trace_stim_pkt_chk.sv
module trace_stim_pkt_chk #(
    parameter int DEPTH  = 16,
    parameter int FILL_W = 5
) (
    input logic              clk,
    input logic              rst,
    input logic              bus_wr,
    input logic [5:0]        bus_addr,
    input logic [31:0]       port_en,
    input logic              ser_en,
    input logic              swo_o,
    input logic              tx_line,
    input logic              tx_busy,
    input logic [FILL_W-1:0] fill,
    input logic              ready
);
    // R13
    fifo_no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
        int'(fill) <= DEPTH);

    // R6
    not_ready_no_growth_chk: assert property (@(posedge clk) disable iff (rst)
        !ready |=> fill <= $past(fill));

    // R7
    disabled_port_drop_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && !bus_addr[5] && !port_en[bus_addr[4:0]] && fill != '0)
        |=> fill <= $past(fill));

    // R11
    line_forced_high_chk: assert property (@(posedge clk) disable iff (rst)
        !ser_en |-> swo_o);

    // R1
    idle_line_high_chk: assert property (@(posedge clk) disable iff (rst)
        !tx_busy |-> tx_line);

    // R1
    stop_bit_high_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(tx_busy) |-> $past(tx_line));

endmodule

bind trace_stim_pkt trace_stim_pkt_chk #(.DEPTH(FIFO_DEPTH), .FILL_W(FILL_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .bus_wr   (bus_wr),
    .bus_addr (bus_addr),
    .port_en  (port_en),
    .ser_en   (ctrl_q.ser_en),
    .swo_o    (swo_o),
    .tx_line  (tx_line),
    .tx_busy  (tx_busy),
    .fill     (fifo_fill),
    .ready    (fifo_room)
);

// File: tb/trace_stim_pkt_test.sv
module trace_stim_pkt_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0;
    logic [5:0]  bus_addr = '0;
    logic [3:0]  bus_strb = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        swo_o;

    always #10 clk = ~clk;   // 50 MHz

    trace_stim_pkt uut (
        .clk       (clk),
        .rst       (rst),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_strb  (bus_strb),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .swo_o     (swo_o)
    );

    typedef struct {
        logic [7:0] val;
        string      tag;
    } exp_t;

    exp_t exp_q[$];
    int   checks = 0;
    int   errors = 0;
    int   frames_seen = 0;
    int   cur_p = 1;
    bit   finished = 1'b0;

    task automatic check(input bit ok, input string tag, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
        end
    endtask

    // All driver tasks start and end at a falling clock edge.
    task automatic bus_write(input logic [5:0] a, input logic [31:0] d, input logic [3:0] s);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d; bus_strb = s;
        @(negedge clk);
        bus_wr = 1'b0;
        if (a == 6'd34 && s == 4'b1111) cur_p = int'(d[15:0]) + 1;
    endtask

    task automatic bus_read_check(input logic [5:0] a, input logic [31:0] exp, input string tag);
        bus_addr = a;
        #1;
        check(bus_rdata == exp, tag, "register read", bus_rdata, exp);
    endtask

    task automatic port_write(input int port, input logic [31:0] d, input logic [3:0] s,
                              input bit accept, input string tag);
        int n;
        logic [1:0] code;
        case (s)
            4'b0001: begin n = 1; code = 2'b01; end
            4'b0011: begin n = 2; code = 2'b10; end
            4'b1111: begin n = 4; code = 2'b11; end
            default: begin n = 0; code = 2'b00; end
        endcase
        if (accept && n != 0) begin
            exp_q.push_back('{val: {port[4:0], 1'b0, code}, tag: tag});
            for (int i = 0; i < n; i++)
                exp_q.push_back('{val: d[i*8 +: 8], tag: tag});
        end
        bus_write(6'(port), d, s);
    endtask

    task automatic wait_drain();
        while (exp_q.size() != 0) @(negedge clk);
        repeat (4) @(negedge clk);
    endtask

    task automatic count_lows(input int cycles, output int lows);
        lows = 0;
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            if (!swo_o) lows++;
        end
    endtask

    // Monitor: decode NRZ frames and compare with the scoreboard queue
    initial begin
        logic prev;
        logic [9:0] bits;
        int lowrun;
        int p;
        exp_t e;
        prev = 1'b1;
        forever begin
            @(negedge clk);
            if (!rst && prev && !swo_o) begin
                p = cur_p;
                lowrun = -1;
                bits = '1;
                for (int c = 0; c < 10 * p; c++) begin
                    if (c > 0) @(negedge clk);
                    if (lowrun < 0 && swo_o) lowrun = c;
                    if (c % p == p / 2) bits[c / p] = swo_o;
                end
                frames_seen++;
                check(bits[9] == 1'b1, "R1", "stop bit", bits[9], 1);
                if (exp_q.size() == 0) begin
                    check(1'b0, "R13", "unexpected frame", bits[8:1], 0);
                end else begin
                    e = exp_q.pop_front();
                    check(bits[8:1] == e.val, e.tag, "line byte", bits[8:1], e.val);
                    if (e.val[0])
                        check(lowrun == p, "R9", "start bit length", lowrun, p);
                end
                prev = 1'b1;
            end else begin
                prev = swo_o;
            end
        end
    end

    // Watchdog
    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            check(1'b0, "WDOG", "watchdog expired", 0, 1);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int f0;
        int lows;
        repeat (4) @(negedge clk);
        rst = 1'b0;

        // Reset state
        check(swo_o == 1'b1, "R1", "idle line after reset", swo_o, 1);
        bus_read_check(6'd33, 32'h0, "R8");
        bus_read_check(6'd0, 32'h1, "R6");

        // Configuration
        bus_write(6'd34, 32'd4, 4'b1111);
        bus_write(6'd32, 32'hFFFF_FFFF, 4'b1111);
        bus_write(6'd33, 32'h0000_150D, 4'b1111);
        bus_read_check(6'd33, 32'h0000_150D, "R8");
        bus_read_check(6'd32, 32'hFFFF_FFFF, "R7");
        bus_read_check(6'd34, 32'd4, "R9");

        // Byte, halfword and word packets
        f0 = frames_seen;
        port_write(3, 32'h0000_00A5, 4'b0001, 1'b1, "R2");
        port_write(7, 32'h0000_BEEF, 4'b0011, 1'b1, "R3");
        port_write(31, 32'h1234_5678, 4'b1111, 1'b1, "R4");
        wait_drain();
        check(frames_seen == f0 + 10, "R13", "frame count", frames_seen, f0 + 10);

        // Bad strobes and a disabled port
        f0 = frames_seen;
        port_write(5, 32'h0000_FF00, 4'b0100, 1'b0, "R5");
        bus_write(6'd32, 32'hFFFF_FFF7, 4'b1111);
        port_write(3, 32'h0000_0011, 4'b0001, 1'b0, "R7");
        port_write(4, 32'h0000_0022, 4'b0001, 1'b1, "R7");
        wait_drain();
        check(frames_seen == f0 + 2, "R7", "frames after dropped writes", frames_seen, f0 + 2);
        bus_write(6'd32, 32'hFFFF_FFFF, 4'b1111);

        // Global enable clear
        f0 = frames_seen;
        bus_write(6'd33, 32'h0000_150C, 4'b1111);
        port_write(4, 32'h0000_0033, 4'b0001, 1'b0, "R8");
        repeat (100) @(negedge clk);
        check(frames_seen == f0, "R8", "frames with global enable clear", frames_seen, f0);
        bus_write(6'd33, 32'h0000_150D, 4'b1111);

        // Ready flag and full FIFO, prescaler 149
        bus_write(6'd34, 32'd149, 4'b1111);
        f0 = frames_seen;
        port_write(0, 32'hA1B2_C3D4, 4'b1111, 1'b1, "R6");
        port_write(1, 32'h0102_0304, 4'b1111, 1'b1, "R6");
        port_write(2, 32'hCAFE_F00D, 4'b1111, 1'b1, "R6");
        bus_read_check(6'd0, 32'h0, "R6");
        port_write(5, 32'h0000_0077, 4'b0001, 1'b0, "R6");
        wait_drain();
        check(frames_seen == f0 + 15, "R6", "frames after full FIFO", frames_seen, f0 + 15);
        bus_read_check(6'd0, 32'h1, "R6");

        // Prescaler 24
        bus_write(6'd34, 32'd24, 4'b1111);
        port_write(0, 32'h0000_005C, 4'b0001, 1'b1, "R9");
        wait_drain();

        // Transmit enable clear holds bytes
        f0 = frames_seen;
        bus_write(6'd33, 32'h0000_1509, 4'b1111);
        port_write(2, 32'h0000_005A, 4'b0001, 1'b1, "R10");
        count_lows(200, lows);
        check(lows == 0, "R10", "line lows while transmit disabled", lows, 0);
        check(frames_seen == f0, "R10", "frames while transmit disabled", frames_seen, f0);
        bus_write(6'd33, 32'h0000_150D, 4'b1111);
        wait_drain();
        check(frames_seen == f0 + 2, "R10", "frames after transmit enable", frames_seen, f0 + 2);

        // Serial output disabled
        f0 = frames_seen;
        bus_write(6'd33, 32'h0000_1505, 4'b1111);
        port_write(6, 32'h0000_0000, 4'b0001, 1'b0, "R11");
        count_lows(600, lows);
        check(lows == 0, "R11", "line lows while output disabled", lows, 0);
        check(frames_seen == f0, "R11", "frames while output disabled", frames_seen, f0);
        bus_write(6'd33, 32'h0000_150D, 4'b1111);

        // Synchronization packet
        bus_write(6'd34, 32'd4, 4'b1111);
        f0 = frames_seen;
        for (int i = 0; i < 5; i++) exp_q.push_back('{val: 8'h00, tag: "R12"});
        exp_q.push_back('{val: 8'h80, tag: "R12"});
        bus_write(6'd33, 32'h0000_150F, 4'b1111);
        wait_drain();
        bus_write(6'd33, 32'h0000_150D, 4'b1111);
        repeat (200) @(negedge clk);
        check(frames_seen == f0 + 6, "R12", "sync frame count", frames_seen, f0 + 6);
        check(exp_q.size() == 0, "R13", "scoreboard empty", exp_q.size(), 0);

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule